// File: doc/BRIEF.md
# Bit-Serial Column Transposition Buffer

This block sits between a row filter that emits one low-pass and one high-pass word per word slot and a single bit-serial column filter. Each word slot lasts W clock cycles, one clock per bit. Every image line of N word slots has two halves. In the first half, the block accepts the N/2 low-pass and N/2 high-pass row outputs. The low-pass word goes straight into the delay chain, and the high-pass word is parked in a half-line buffer. In the second half, the upstream filter is stalled and the parked high-pass words are sent into the chain in their arrival order.

The word chosen for a slot is serialized least significant bit first. It then passes through a chain of eight line delays, each N·W bits long. As a result, the nine output bits in any clock cycle are the same bit of the same column position, taken from the current line and the eight lines before it. The column filter therefore receives low-pass column vectors in the first half of each line and high-pass column vectors in the second half.

Vertical decimation by two is built in. The output vector is marked valid only on even-numbered lines, and only once nine lines have entered the chain.

Top module: `colbuf_transpose`

## Requirements
- R1: While reset is held and just after it, `slice` is all zero, `slice_valid` is 0 and `slice_bit` is W-1.
- R2: `take` is 1 exactly in the last bit cycle of a slot whose following slot lies in the first half of a line (slot index 0 to N/2-1). The slot counter starts at 0 after reset, so `take` is also 1 in the first cycle after reset. `in_valid`, `in_lo` and `in_hi` are sampled on the clock edge that ends that cycle.
- R3: `slice[0]` carries the word of the displayed slot, least significant bit first. `slice_bit` gives the bit index, which runs 0 to W-1 within each slot.
- R4: For k from 1 to 8, `slice[k]` equals the value `slice[0]` had exactly k·N·W clock cycles earlier. That is the same bit of the same column of the line k lines back, or 0 where that line precedes the first line.
- R5: In line slots 0 to N/2-1 the chain word is the low-pass input of that slot. In slots N/2 to N/2+j it is the high-pass word accepted in slot j of the same line.
- R6: When `in_valid` is 0 at a sampling edge of R2, both words of that slot enter as zero, whatever is on `in_lo` and `in_hi`.
- R7: Inputs present at any edge where `take` is 0 have no effect on any output.
- R8: `slice_valid` is 1 exactly during lines with index at least 8 (the first line after reset is line 0) whose index is even.
- R9: `slice_band` is 0 for slots 0 to N/2-1 of a line (low-pass data) and 1 for the rest (high-pass data).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Row pair present at the sampling edge |
| in_lo | input | W | Low-pass row output word |
| in_hi | input | W | High-pass row output word |
| take | output | 1 | Row pair will be sampled on the coming edge |
| slice | output | 9 | Bit-slice of nine vertically adjacent values; bit k is k lines back |
| slice_bit | output | $clog2(W) | Bit index of the current slice |
| slice_band | output | 1 | 0 for a low-pass column vector, 1 for high-pass |
| slice_valid | output | 1 | Vector is usable by the column filter |

## Verification
The hardest condition to reach is the deepest tap showing real data. Several lines of stimulus must be fed before `slice[8]` holds anything but zeros, and the low-pass and high-pass halves must remain separable after eight line delays. Each scenario therefore streams twenty lines with distinct pseudo-random words and compares all nine taps in every bit cycle against a line-indexed record of what was accepted. Separate scenarios drop `in_valid` in scattered slots and drive live data while `take` is low, so that zeroing and ignored inputs show up in the deepest taps as well as the shallow ones.

// File: rtl/tpose_pkg.sv
package tpose_pkg;

  // Slot positions in the first half of a line carry low-pass data.
  function automatic logic is_low_slot(input int unsigned col, input int unsigned n);
    return col < (n / 2);
  endfunction

  // Fill count reached once every tap of the chain holds a real line.
  function automatic logic chain_full(input int unsigned cnt, input int unsigned taps);
    return cnt >= taps;
  endfunction

endpackage

// File: rtl/tpose_seq.sv
module tpose_seq
  import tpose_pkg::*;
#(
  parameter int W = 12,
  parameter int N = 16,
  parameter int TAPS = 9
) (
  input  logic                              clk,
  input  logic                              rst,
  output logic [(W > 1 ? $clog2(W) : 1)-1:0] bit_idx,
  output logic                              slot_load,
  output logic                              nxt_low,
  output logic                              line_wrap,
  output logic                              band,
  output logic                              filled,
  output logic                              line_odd
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam int FW = $clog2(TAPS + 1);

  logic [CW-1:0] col;
  logic [CW-1:0] nxt_col;
  logic [FW-1:0] fcnt;

  always_comb begin
    slot_load = (bit_idx == BW'(W - 1));
    line_wrap = slot_load && (col == CW'(N - 1));
    nxt_col   = (col == CW'(N - 1)) ? '0 : col + 1'b1;
    nxt_low   = is_low_slot(32'(nxt_col), N);
    band      = !is_low_slot(32'(col), N);
    filled    = chain_full(32'(fcnt), TAPS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx  <= BW'(W - 1);
      col      <= CW'(N - 1);
      fcnt     <= '0;
      line_odd <= 1'b1;
    end else if (slot_load) begin
      bit_idx <= '0;
      col     <= nxt_col;
      if (line_wrap) begin
        line_odd <= ~line_odd;
        if (!filled) fcnt <= fcnt + 1'b1;
      end
    end else begin
      bit_idx <= bit_idx + 1'b1;
    end
  end
endmodule

// File: rtl/tpose_halfbuf.sv
module tpose_halfbuf #(
  parameter int W = 12,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] head
);
  logic [W-1:0] mem [DEPTH];

  assign head = mem[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (shift) begin
      for (int k = 0; k < DEPTH - 1; k++) mem[k] <= mem[k+1];
      mem[DEPTH-1] <= din;
    end
  end
endmodule

// File: rtl/tpose_piso.sv
module tpose_piso #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         bit_out
);
  logic [W-1:0] q;

  assign bit_out = q[0];

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= word;
    else           q <= {1'b0, q[W-1:1]};
  end
endmodule

// File: rtl/tpose_linedelay.sv
module tpose_linedelay #(
  parameter int LEN = 192
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] sr;

  assign dout = sr[0];

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {din, sr[LEN-1:1]};
  end
endmodule

// File: rtl/colbuf_transpose.sv
module colbuf_transpose #(
  parameter int W = 12,
  parameter int N = 16,
  parameter int TAPS = 9
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  input  logic [W-1:0]                      in_lo,
  input  logic [W-1:0]                      in_hi,
  output logic                              take,
  output logic [TAPS-1:0]                   slice,
  output logic [(W > 1 ? $clog2(W) : 1)-1:0] slice_bit,
  output logic                              slice_band,
  output logic                              slice_valid
);
  localparam int HALF = N / 2;
  localparam int LINE_BITS = N * W;

  logic         slot_load;
  logic         nxt_low;
  logic         line_wrap;
  logic         filled;
  logic         line_odd;
  logic [W-1:0] hb_head;
  logic [W-1:0] hb_din;
  logic [W-1:0] chain_word;
  logic [TAPS-1:0] tap;

  tpose_seq #(.W(W), .N(N), .TAPS(TAPS)) u_seq (
    .clk(clk), .rst(rst), .bit_idx(slice_bit), .slot_load(slot_load),
    .nxt_low(nxt_low), .line_wrap(line_wrap), .band(slice_band),
    .filled(filled), .line_odd(line_odd)
  );

  always_comb begin
    take = slot_load && nxt_low;
    if (nxt_low) begin
      chain_word = in_valid ? in_lo : '0;
      hb_din     = in_valid ? in_hi : '0;
    end else begin
      chain_word = hb_head;
      hb_din     = '0;
    end
  end

  tpose_halfbuf #(.W(W), .DEPTH(HALF)) u_hbuf (
    .clk(clk), .rst(rst), .shift(slot_load), .din(hb_din), .head(hb_head)
  );

  tpose_piso #(.W(W)) u_piso (
    .clk(clk), .rst(rst), .load(slot_load), .word(chain_word), .bit_out(tap[0])
  );

  for (genvar g = 1; g < TAPS; g++) begin : g_line
    tpose_linedelay #(.LEN(LINE_BITS)) u_dly (
      .clk(clk), .rst(rst), .din(tap[g-1]), .dout(tap[g])
    );
  end

  assign slice       = tap;
  assign slice_valid = filled && !line_odd;
endmodule

// File: rtl/colbuf_transpose_chk.sv
module colbuf_transpose_chk #(
  parameter int W = 12
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              take,
  input logic                              slot_load,
  input logic                              line_wrap,
  input logic [(W > 1 ? $clog2(W) : 1)-1:0] slice_bit,
  input logic                              slice_band,
  input logic                              slice_valid
);
  localparam int BW = (W > 1) ? $clog2(W) : 1;

  // R2: an accepted pair is followed by the first bit of a low-pass slot
  a_r2_take_starts_low: assert property (@(posedge clk) disable iff (rst)
    take |=> (slice_bit == '0) && !slice_band);

  // R3: bit index advances by one inside a slot
  a_r3_bit_advance: assert property (@(posedge clk) disable iff (rst)
    (slice_bit != BW'(W - 1)) |=> (slice_bit == $past(slice_bit) + 1'b1));

  // R3: a slot boundary returns the index to zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    slot_load |=> (slice_bit == '0));

  // R9: band changes only at the first bit of a slot
  a_r9_band_edge: assert property (@(posedge clk) disable iff (rst)
    ($rose(slice_band) || $fell(slice_band)) |-> (slice_bit == '0));

  // R8: a valid stretch starts at the head of a line
  a_r8_valid_start: assert property (@(posedge clk) disable iff (rst)
    $rose(slice_valid) |-> ((slice_bit == '0) && !slice_band));

  // R8: the line after a valid line is skipped
  a_r8_decimate: assert property (@(posedge clk) disable iff (rst)
    (slice_valid && line_wrap) |=> !slice_valid);
endmodule

bind colbuf_transpose colbuf_transpose_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .take(take), .slot_load(slot_load),
  .line_wrap(line_wrap), .slice_bit(slice_bit), .slice_band(slice_band),
  .slice_valid(slice_valid)
);

// File: tb/colbuf_transpose_test.sv
module colbuf_transpose_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int N = 8;
  localparam int TAPS = 9;
  localparam int H = N / 2;
  localparam int BW = $clog2(W);
  localparam int LINES = 20;
  localparam int TOT = LINES * N * W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_lo = '0;
  logic [W-1:0] in_hi = '0;
  logic take;
  logic [TAPS-1:0] slice;
  logic [BW-1:0] slice_bit;
  logic slice_band;
  logic slice_valid;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5678;

  logic [W-1:0] exp_lo [LINES][H];
  logic [W-1:0] exp_hi [LINES][H];

  colbuf_transpose #(.W(W), .N(N), .TAPS(TAPS)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_lo(in_lo), .in_hi(in_hi),
    .take(take), .slice(slice), .slice_bit(slice_bit),
    .slice_band(slice_band), .slice_valid(slice_valid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [W-1:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return W'(seed >> 13);
  endfunction

  task automatic check(input string tag, input string what, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic apply_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    in_lo = '0;
    in_hi = '0;
    for (int l = 0; l < LINES; l++)
      for (int j = 0; j < H; j++) begin
        exp_lo[l][j] = '0;
        exp_hi[l][j] = '0;
      end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: held reset state
    check("R1", "slice in reset", int'(slice), 0);
    check("R1", "valid in reset", int'(slice_valid), 0);
    rst = 1'b0;
  endtask

  // bit of the word held by line l, column position col
  function automatic logic exp_bit(input int l, input int col, input int b);
    if (l < 0) return 1'b0;
    if (col < H) return exp_lo[l][col][b];
    return exp_hi[l][col-H][b];
  endfunction

  task automatic check_cycle(input int c, input int mode);
    int s, b, col, ln;
    string dtag;
    logic [TAPS-1:0] ev;
    if (c == 0) begin
      check("R1", "slice after reset", int'(slice), 0);
      check("R1", "bit after reset", int'(slice_bit), W - 1);
      check("R1", "valid after reset", int'(slice_valid), 0);
    end else begin
      s = (c - 1) / W;
      b = (c - 1) % W;
      col = s % N;
      ln = s / N;
      for (int k = 0; k < TAPS; k++) ev[k] = exp_bit(ln - k, col, b);
      dtag = (mode == 1) ? "R6" : (mode == 2) ? "R7" : (col >= H) ? "R5" : "R4";
      check("R3", "bit index", int'(slice_bit), b);
      check("R3", "tap0", int'(slice[0]), int'(ev[0]));
      check(dtag, "taps", int'(slice), int'(ev));
      check("R9", "band", int'(slice_band), (col >= H) ? 1 : 0);
      check("R8", "valid", int'(slice_valid), (ln >= 8 && (ln % 2) == 0) ? 1 : 0);
    end
    // R2: sampling cycle computed from the slot count
    check("R2", "take", int'(take), ((c % W) == 0 && ((c / W) % N) < H) ? 1 : 0);
  endtask

  task automatic drive_cycle(input int c, input int mode);
    int slot, ln, col;
    logic v;
    logic [W-1:0] lo, hi;
    slot = c / W;
    ln = slot / N;
    col = slot % N;
    lo = rnd();
    hi = rnd();
    if ((c % W) == 0 && col < H) begin
      v = (mode == 1) ? (((slot * 7) % 3) != 0) : 1'b1;
      in_valid = v;
      in_lo = lo;
      in_hi = hi;
      exp_lo[ln][col] = v ? lo : '0;
      exp_hi[ln][col] = v ? hi : '0;
    end else if (mode == 2) begin
      // R7: live-looking data while the block is not sampling
      in_valid = 1'b1;
      in_lo = lo;
      in_hi = hi;
    end else begin
      in_valid = 1'b0;
      in_lo = (mode == 1) ? lo : '0;
      in_hi = (mode == 1) ? hi : '0;
    end
  endtask

  task automatic run_stream(input int mode);
    apply_reset();
    for (int c = 0; c < TOT; c++) begin
      check_cycle(c, mode);
      drive_cycle(c, mode);
      @(negedge clk);
    end
  endtask

  // R3 R4 R5 R8 R9: every pair valid
  task automatic test_full_stream();
    run_stream(0);
  endtask

  // R6: scattered missing pairs enter as zero
  task automatic test_gaps();
    run_stream(1);
  endtask

  // R7: traffic outside sampling edges has no effect
  task automatic test_noise();
    run_stream(2);
  endtask

  initial begin
    test_full_stream();
    test_gaps();
    test_noise();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule